// File: doc/BRIEF.md
# BT Host Register Interface

This block is the host-facing register file of a block-transfer style management interface. A host reaches it through a byte-wide register port with three live offsets: a control and status byte, a data port that serves two separate message buffers, and an interrupt mask byte. The host writes a request byte by byte into the inbound buffer through the data port. It then raises its attention bit in the control byte. The block marks itself busy and sends a one-cycle request-ready strobe to a downstream message engine.

The engine reads the request out of the inbound buffer through its own read port and fills the outbound buffer through a write port. It loads the response length and then reports completion. Completion sets the response attention flag and drops the busy flag. The host drains the response through the same data port. Draining the last byte empties the buffer, and any further read returns 0xFF. Interrupt generation, message parsing and the bus adapter are outside this block.

Top module: `bt_host_regs`

## Requirements
- R1: After synchronous reset the control byte and the mask byte read 0x00, `in_count` is 0, `req_ready` is 0 and `host_rdata` is 0x00.
- R2: A read at offset 3 returns 0xFF, and a write at offset 3 leaves the control and mask bytes unchanged.
- R3: A control write (offset 0) with bit 2 set sets the engine-busy flag, which reads back in control bit 7. It also drives `req_ready` high for exactly the one cycle after the write is sampled.
- R4: A control write with bit 6 set inverts the host-busy flag, which reads back in control bit 6.
- R5: A control write with bit 3 set clears the response attention flag (control bit 3), and one with bit 4 set clears the service attention flag (control bit 4). A 0 in either position leaves that flag as it was.
- R6: A control write with bit 0 set returns `in_count` to 0.
- R7: Each write to the data port (offset 1) stores the byte at index `in_count`, but only while `in_count` is below DEPTH. `in_count` increments on every such write and saturates at all ones, so an overrun neither overwrites stored bytes nor goes unseen.
- R8: Reads of the data port return the outbound bytes in index order while the read index is below the loaded length. Reading the last byte empties the buffer, and reads with nothing left return 0xFF.
- R9: A control write with bit 1 set returns the outbound read index to 0, so the response can be read again from its first byte.
- R10: An `eng_resp_done` pulse sets the response attention flag and clears the engine-busy flag. An `eng_sms_req` pulse sets the service attention flag.
- R11: A write to the mask byte (offset 2) keeps bits 1:0, which read back, and reads 0 in bits 7:2.
- R12: `host_rdata` holds the result of a read from the cycle after the read strobe until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register offset |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read result, valid the cycle after `host_rd` |
| req_ready | output | 1 | One-cycle strobe: a request waits in the inbound buffer |
| in_count | output | CNT_W | Inbound byte count, overrun included |
| eng_in_addr | input | IDX_W | Engine read index into the inbound buffer |
| eng_in_data | output | 8 | Inbound byte, one cycle after `eng_in_addr` |
| eng_out_we | input | 1 | Engine write strobe into the outbound buffer |
| eng_out_addr | input | IDX_W | Outbound write index |
| eng_out_data | input | 8 | Outbound write byte |
| eng_out_len_we | input | 1 | Load the outbound length |
| eng_out_len | input | CNT_W | Outbound length, clamped to DEPTH |
| eng_resp_done | input | 1 | Response ready: set attention, clear engine busy |
| eng_sms_req | input | 1 | Set the service attention flag |

## Verification
A wrong flag bit shows up at the next control read, one cycle after the strobe. A wrong inbound count shows up on `in_count` one cycle after the write. A stale outbound index or length makes the next data-port read return a byte out of order, or 0xFF too early or too late. The overrun case matters most: a missing bound on the store would overwrite the first stored bytes, and this is seen as soon as the engine reads index 0 back. A request-ready strobe that is lost or lasts too long is seen on `req_ready` within one cycle of the control write.

// File: rtl/bt_regs_pkg.sv
package bt_regs_pkg;
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;

  localparam int CB_CLR_IN    = 0;
  localparam int CB_CLR_OUT   = 1;
  localparam int CB_HOST_ATN  = 2;
  localparam int CB_RESP_ATN  = 3;
  localparam int CB_SVC_ATN   = 4;
  localparam int CB_HOST_BUSY = 6;
  localparam int CB_ENG_BUSY  = 7;

  localparam logic [7:0] EMPTY_BYTE = 8'hFF;

  typedef struct packed {
    logic eng_busy;
    logic host_busy;
    logic svc_atn;
    logic resp_atn;
  } ctrl_flags_t;
endpackage

// File: rtl/bt_ctrl_flags.sv
module bt_ctrl_flags
  import bt_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic [7:0] wdata,
  input  logic       resp_done,
  input  logic       sms_req,
  output logic [7:0] ctrl_byte,
  output logic       req_pulse
);
  ctrl_flags_t flags_q;
  ctrl_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (ctrl_wr) begin
      if (wdata[CB_RESP_ATN])  flags_d.resp_atn  = 1'b0;
      if (wdata[CB_SVC_ATN])   flags_d.svc_atn   = 1'b0;
      if (wdata[CB_HOST_BUSY]) flags_d.host_busy = ~flags_q.host_busy;
      if (wdata[CB_HOST_ATN])  flags_d.eng_busy  = 1'b1;
    end
    // engine events land after the host write in the same cycle
    if (resp_done) begin
      flags_d.resp_atn = 1'b1;
      flags_d.eng_busy = 1'b0;
    end
    if (sms_req) flags_d.svc_atn = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '0;
      req_pulse <= 1'b0;
    end else begin
      flags_q   <= flags_d;
      req_pulse <= ctrl_wr && wdata[CB_HOST_ATN];
    end
  end

  always_comb begin
    ctrl_byte               = 8'h00;
    ctrl_byte[CB_RESP_ATN]  = flags_q.resp_atn;
    ctrl_byte[CB_SVC_ATN]   = flags_q.svc_atn;
    ctrl_byte[CB_HOST_BUSY] = flags_q.host_busy;
    ctrl_byte[CB_ENG_BUSY]  = flags_q.eng_busy;
  end
endmodule

// File: rtl/bt_inbound_buf.sv
module bt_inbound_buf #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CAP     = CNT_W'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       store;

  assign store = push && (count < CAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (push && count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[count[IDX_W-1:0]] <= push_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/bt_outbound_buf.sv
module bt_outbound_buf #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             len_we,
  input  logic [CNT_W-1:0] len_in,
  input  logic             clr_idx,
  input  logic             pop,
  output logic [7:0]       byte_q,
  output logic             hit_q
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_clamped;
  logic             hit;
  logic             last;

  assign len_clamped = (len_in > CAP) ? CAP : len_in;
  assign hit  = idx_q < len_q;
  assign last = (idx_q + 1'b1) == len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      len_q <= '0;
      hit_q <= 1'b0;
    end else begin
      if (pop) hit_q <= hit;
      if (clr_idx) begin
        idx_q <= '0;
      end else if (pop && hit) begin
        idx_q <= last ? '0 : idx_q + 1'b1;
      end
      if (len_we) begin
        len_q <= len_clamped;
      end else if (pop && hit && last) begin
        len_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (pop && hit) byte_q <= mem[idx_q[IDX_W-1:0]];
  end
endmodule

// File: rtl/bt_host_regs.sv
module bt_host_regs
  import bt_regs_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MASK_BITS = 2,
  parameter int IDX_W     = $clog2(DEPTH),
  parameter int CNT_W     = $clog2(DEPTH) + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             req_ready,
  output logic [CNT_W-1:0] in_count,
  input  logic [IDX_W-1:0] eng_in_addr,
  output logic [7:0]       eng_in_data,
  input  logic             eng_out_we,
  input  logic [IDX_W-1:0] eng_out_addr,
  input  logic [7:0]       eng_out_data,
  input  logic             eng_out_len_we,
  input  logic [CNT_W-1:0] eng_out_len,
  input  logic             eng_resp_done,
  input  logic             eng_sms_req
);
  logic                 wr_ctrl, wr_data, wr_mask, rd_data;
  logic [7:0]           ctrl_byte;
  logic [MASK_BITS-1:0] mask_q;
  logic [7:0]           mask_byte;
  logic [7:0]           reg_q;
  logic                 buf_sel_q;
  logic [7:0]           out_byte;
  logic                 out_hit;

  assign wr_ctrl = host_wr && (host_addr == OFS_CTRL);
  assign wr_data = host_wr && (host_addr == OFS_DATA);
  assign wr_mask = host_wr && (host_addr == OFS_MASK);
  assign rd_data = host_rd && (host_addr == OFS_DATA);

  bt_ctrl_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (wr_ctrl),
    .wdata     (host_wdata),
    .resp_done (eng_resp_done),
    .sms_req   (eng_sms_req),
    .ctrl_byte (ctrl_byte),
    .req_pulse (req_ready)
  );

  bt_inbound_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_inbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_data),
    .push_data (host_wdata),
    .clr       (wr_ctrl && host_wdata[CB_CLR_IN]),
    .rd_addr   (eng_in_addr),
    .rd_data   (eng_in_data),
    .count     (in_count)
  );

  bt_outbound_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_outbuf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (eng_out_we),
    .wr_addr (eng_out_addr),
    .wr_data (eng_out_data),
    .len_we  (eng_out_len_we),
    .len_in  (eng_out_len),
    .clr_idx (wr_ctrl && host_wdata[CB_CLR_OUT]),
    .pop     (rd_data),
    .byte_q  (out_byte),
    .hit_q   (out_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (wr_mask) mask_q <= host_wdata[MASK_BITS-1:0];
  end

  assign mask_byte = 8'(mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= 8'h00;
      buf_sel_q <= 1'b0;
    end else if (host_rd) begin
      buf_sel_q <= (host_addr == OFS_DATA);
      case (host_addr)
        OFS_CTRL: reg_q <= ctrl_byte;
        OFS_MASK: reg_q <= mask_byte;
        default:  reg_q <= EMPTY_BYTE;
      endcase
    end
  end

  assign host_rdata = buf_sel_q ? (out_hit ? out_byte : EMPTY_BYTE) : reg_q;
endmodule

// File: rtl/bt_host_regs_chk.sv
module bt_host_regs_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       host_addr,
  input logic             host_wr,
  input logic             host_rd,
  input logic [7:0]       host_wdata,
  input logic [7:0]       host_rdata,
  input logic             req_ready,
  input logic [CNT_W-1:0] in_count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> $past(host_wr && host_addr == 2'd0 && host_wdata[2])); // R3

  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd0 && host_wdata[0]) |=> in_count == '0); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd1 && in_count != CMAX)
      |=> in_count == $past(in_count) + 1'b1); // R7

  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd1 && in_count == CMAX) |=> in_count == CMAX); // R7

  AST_BAD_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 2'd3) |=> host_rdata == 8'hFF); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata)); // R12
endmodule

bind bt_host_regs bt_host_regs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .req_ready  (req_ready),
  .in_count   (in_count)
);

// File: tb/tb_bt_host_regs.sv
`timescale 1ns/1ps
module tb_bt_host_regs;
  localparam int DEPTH = 64;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH) + 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       host_addr = '0;
  logic             host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]       host_wdata = '0;
  logic [7:0]       host_rdata;
  logic             req_ready;
  logic [CNT_W-1:0] in_count;
  logic [IDX_W-1:0] eng_in_addr = '0;
  logic [7:0]       eng_in_data;
  logic             eng_out_we = 1'b0;
  logic [IDX_W-1:0] eng_out_addr = '0;
  logic [7:0]       eng_out_data = '0;
  logic             eng_out_len_we = 1'b0;
  logic [CNT_W-1:0] eng_out_len = '0;
  logic             eng_resp_done = 1'b0, eng_sms_req = 1'b0;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  bt_host_regs #(.DEPTH(DEPTH)) dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic eng_peek(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk); eng_in_addr = IDX_W'(a);
    @(negedge clk); check(tag, eng_in_data, exp);
  endtask

  task automatic eng_put(input int a, input logic [7:0] d);
    @(negedge clk); eng_out_addr = IDX_W'(a); eng_out_data = d; eng_out_we = 1'b1;
    @(negedge clk); eng_out_we = 1'b0;
  endtask

  task automatic eng_len(input int n);
    @(negedge clk); eng_out_len = CNT_W'(n); eng_out_len_we = 1'b1;
    @(negedge clk); eng_out_len_we = 1'b0;
  endtask

  // monitor: pops expected read results one cycle after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (host_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("monitor-underflow", 1, 0);
        else check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(8ns * 200000);
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", host_rdata, 8'h00);
    check("R1 in_count", in_count, 0);
    check("R1 req_ready", req_ready, 0);
    hread(2'd0, 8'h00, "R1 ctrl");
    hread(2'd2, 8'h00, "R1 mask");
    // R2 unused offset
    hread(2'd3, 8'hFF, "R2 read offset3");
    hwrite(2'd3, 8'hFF);
    hread(2'd0, 8'h00, "R2 ctrl after offset3 write");
    hread(2'd2, 8'h00, "R2 mask after offset3 write");
    // R7 inbound store
    hwrite(2'd1, 8'h11); hwrite(2'd1, 8'h22); hwrite(2'd1, 8'h33);
    check("R7 count3", in_count, 3);
    eng_peek(0, 8'h11, "R7 byte0");
    eng_peek(2, 8'h33, "R7 byte2");
    // R3 host attention
    hwrite(2'd0, 8'h04);
    check("R3 req high", req_ready, 1);
    @(negedge clk);
    check("R3 req one cycle", req_ready, 0);
    hread(2'd0, 8'h80, "R3 engine busy");
    // R4 toggle host busy
    hwrite(2'd0, 8'h40);
    hread(2'd0, 8'hC0, "R4 host busy set");
    hwrite(2'd0, 8'h40);
    hread(2'd0, 8'h80, "R4 host busy cleared");
    // R10 engine events
    @(negedge clk); eng_resp_done = 1'b1; @(negedge clk); eng_resp_done = 1'b0;
    hread(2'd0, 8'h08, "R10 resp done");
    @(negedge clk); eng_sms_req = 1'b1; @(negedge clk); eng_sms_req = 1'b0;
    hread(2'd0, 8'h18, "R10 sms");
    // R5 attention clears
    hwrite(2'd0, 8'h08);
    hread(2'd0, 8'h10, "R5 resp atn cleared");
    hwrite(2'd0, 8'h00);
    hread(2'd0, 8'h10, "R5 zero write keeps");
    hwrite(2'd0, 8'h10);
    hread(2'd0, 8'h00, "R5 sms cleared");
    // R6 clear inbound count
    hwrite(2'd0, 8'h01);
    check("R6 count cleared", in_count, 0);
    // R7 overrun
    for (int i = 0; i < DEPTH + 2; i++) hwrite(2'd1, 8'(i) ^ 8'hA5);
    check("R7 overrun count", in_count, DEPTH + 2);
    eng_peek(0, 8'hA5, "R7 byte0 kept");
    eng_peek(1, 8'hA4, "R7 byte1 kept");
    eng_peek(DEPTH - 1, 8'(DEPTH - 1) ^ 8'hA5, "R7 last byte");
    for (int i = 0; i < 200; i++) hwrite(2'd1, 8'h00);
    check("R7 saturate", in_count, (1 << CNT_W) - 1);
    hwrite(2'd0, 8'h01);
    // R8 outbound drain
    for (int i = 0; i < 4; i++) eng_put(i, 8'hD0 + 8'(i));
    eng_len(4);
    for (int i = 0; i < 4; i++) hread(2'd1, 8'hD0 + 8'(i), "R8 drain");
    hread(2'd1, 8'hFF, "R8 empty");
    // R9 re-read
    for (int i = 0; i < 3; i++) eng_put(i, 8'hE0 + 8'(i));
    eng_len(3);
    hread(2'd1, 8'hE0, "R9 first");
    hread(2'd1, 8'hE1, "R9 second");
    hwrite(2'd0, 8'h02);
    for (int i = 0; i < 3; i++) hread(2'd1, 8'hE0 + 8'(i), "R9 reread");
    hread(2'd1, 8'hFF, "R9 empty");
    // R11 mask
    hwrite(2'd2, 8'hFF);
    hread(2'd2, 8'h03, "R11 mask ff");
    hwrite(2'd2, 8'h01);
    hread(2'd2, 8'h01, "R11 mask 01");
    // R12 hold
    hwrite(2'd0, 8'h40);
    repeat (3) @(negedge clk);
    check("R12 rdata held", host_rdata, 8'h01);
    repeat (3) @(negedge clk);
    check("R12 queue drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule